// File: doc/BRIEF.md
# Saturating Up/Down Tap Position Controller

This block is the control logic for one channel of a digitally stepped resistor tap selector. A host drives three slow, asynchronous control lines: an active-low select, a step strobe and a direction level. The block samples them with the system clock and keeps a 5-bit tap position. It decodes that position into a one-hot enable for 32 tap switches. While the channel is selected, every falling edge of the step strobe moves the position one place, and the position stops at either end instead of wrapping.

When select is released, the level of the step strobe decides what happens. If it is high, the live position is written into a nonvolatile store, and a busy period follows. During that period the position is frozen and all inputs are ignored. Afterwards the channel rests in standby. If it is low, the channel returns to standby without writing, and the live position stays in force. The store is modelled as a register that keeps its value through the synchronous reset, and that reset stands in for a power cycle. Coming out of reset, the counter holds the stored value. Before any write, it holds a parameterised initial value.

The controller is a four-state machine. ST_RECALL is the single cycle after reset and always moves to ST_STANDBY. ST_STANDBY moves to ST_ACTIVE once select is seen low. ST_ACTIVE moves to ST_STORE when select is seen high with the step level high (the save exit), or to ST_STANDBY when select is seen high with the step level low (the plain exit). ST_STORE returns to ST_STANDBY after STORE_CYCLES clock cycles.

Top module: `tapsel_ctrl`

## Requirements
- R1: `tap_o` always has exactly one bit set, and that bit is bit number `pos_o`.
- R2: While the channel is selected (ST_ACTIVE), each falling edge of `step_i` changes `pos_o` by exactly one: up when `dir_i` is 1, down when `dir_i` is 0.
- R3: A step up at position 31 leaves the position at 31, and a step down at position 0 leaves it at 0. The position never wraps.
- R4: Releasing select (`sel_n_i` 0 to 1) while `step_i` is 1 writes the current position into the nonvolatile store.
- R5: Releasing select while `step_i` is 0 writes nothing, and `pos_o` keeps the live value.
- R6: After reset, `pos_o` equals the last stored position. If nothing was ever stored, it equals SAVED_INIT.
- R7: A store holds `busy_o` at 1 for exactly STORE_CYCLES clock cycles. After that, `standby_o` is 1 while select stays high.
- R8: While `busy_o` is 1, step edges and a new selection have no effect on `pos_o`.
- R9: `dir_i` may change between steps within one selection, and each step follows the direction level present at its edge.
- R10: `standby_o` is 0 while the channel is selected and 1 after a plain exit. `busy_o` and `standby_o` are never both 1.
- R11: Step edges while the channel is deselected do not change `pos_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, models a power cycle |
| sel_n_i | input | 1 | Channel select, active low, asynchronous |
| step_i | input | 1 | Step strobe, acts on its falling edge, asynchronous |
| dir_i | input | 1 | Step direction: 1 up, 0 down, asynchronous |
| tap_o | output | 2**POS_W | One-hot tap switch enable |
| pos_o | output | POS_W | Current tap position |
| busy_o | output | 1 | Store in progress |
| standby_o | output | 1 | Channel idle and deselected |

## Verification
The bench builds the block with STORE_CYCLES = 20 instead of the multi-million default. This puts the whole store window within reach. The bench can measure its exact length, and it can push step edges and a reselection into the middle of that window. SAVED_INIT = 3 is used so that a first power-up with an empty store can be told apart from a counter that simply clears to zero. The default 5-bit width keeps both saturation ends reachable in a few dozen steps.

// File: rtl/tapsel_pkg.sv
package tapsel_pkg;

    typedef enum logic [1:0] {
        ST_RECALL  = 2'd0,
        ST_STANDBY = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_STORE   = 2'd3
    } tap_state_e;

endpackage

// File: rtl/tapsel_sync.sv
module tapsel_sync #(
    parameter int               N       = 3,
    parameter logic [N-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_bit
            logic meta_q;
            logic stab_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    meta_q <= RST_VAL[gi];
                    stab_q <= RST_VAL[gi];
                end else begin
                    meta_q <= d[gi];
                    stab_q <= meta_q;
                end
            end
            assign q[gi] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/tapsel_nvstore.sv
module tapsel_nvstore #(
    parameter int               W    = 5,
    parameter logic [W-1:0]     INIT = '0
) (
    input  logic         clk,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data
);

    // Deliberately outside the reset domain: survives a modelled power cycle.
    logic [W-1:0] cell_q = INIT;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cell_q <= wr_data;
        end
    end

    assign rd_data = cell_q;

endmodule

// File: rtl/tapsel_counter.sv
module tapsel_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] load_val,
    input  logic         up_en,
    input  logic         dn_en,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] BOT = '0;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= load_val;
        end else if (up_en && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dn_en && (cnt_q != BOT)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign q = cnt_q;

endmodule

// File: rtl/tapsel_decode.sv
module tapsel_decode #(
    parameter int W = 5,
    localparam int N = 1 << W
) (
    input  logic [W-1:0] pos,
    output logic [N-1:0] onehot
);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_tap
            assign onehot[gi] = (pos == W'(gi));
        end
    endgenerate

endmodule

// File: rtl/tapsel_ctrl.sv
module tapsel_ctrl
    import tapsel_pkg::*;
#(
    parameter int                 POS_W        = 5,
    parameter int                 STORE_CYCLES = 2_500_000,
    parameter logic [POS_W-1:0]   SAVED_INIT   = '0,
    localparam int                TAPS         = 1 << POS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n_i,
    input  logic              step_i,
    input  logic              dir_i,
    output logic [TAPS-1:0]   tap_o,
    output logic [POS_W-1:0]  pos_o,
    output logic              busy_o,
    output logic              standby_o
);

    localparam int               CNT_W     = $clog2(STORE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(STORE_CYCLES - 1);
    localparam logic [2:0]       SYNC_RST  = 3'b001; // {dir, step, sel_n}

    tap_state_e        state_q, state_d;
    logic [CNT_W-1:0]  wait_q;
    logic [2:0]        sync_s;
    logic              sel_n_s, step_s, dir_s;
    logic              step_prev_q;
    logic              step_fall;
    logic              up_en, dn_en, nv_wr;
    logic [POS_W-1:0]  nv_val;

    tapsel_sync #(.N(3), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({dir_i, step_i, sel_n_i}),
        .q   (sync_s)
    );

    assign sel_n_s = sync_s[0];
    assign step_s  = sync_s[1];
    assign dir_s   = sync_s[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            step_prev_q <= 1'b0;
        end else begin
            step_prev_q <= step_s;
        end
    end

    assign step_fall = step_prev_q & ~step_s;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RECALL;
        end else begin
            state_q <= state_d;
        end
    end

    // Store window counter
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
        end else if (state_q == ST_STORE) begin
            wait_q <= wait_q + 1'b1;
        end else begin
            wait_q <= '0;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RECALL:  state_d = ST_STANDBY;
            ST_STANDBY: if (!sel_n_s) state_d = ST_ACTIVE;
            ST_ACTIVE:  if (sel_n_s)  state_d = step_s ? ST_STORE : ST_STANDBY;
            ST_STORE:   if (wait_q == CNT_LAST) state_d = ST_STANDBY;
        endcase
    end

    // Outputs and datapath strobes
    always_comb begin
        busy_o    = 1'b0;
        standby_o = 1'b0;
        nv_wr     = 1'b0;
        up_en     = 1'b0;
        dn_en     = 1'b0;
        unique case (state_q)
            ST_RECALL:  ;
            ST_STANDBY: standby_o = 1'b1;
            ST_ACTIVE: begin
                if (sel_n_s) begin
                    nv_wr = step_s;
                end else if (step_fall) begin
                    up_en = dir_s;
                    dn_en = ~dir_s;
                end
            end
            ST_STORE:   busy_o = 1'b1;
        endcase
    end

    tapsel_nvstore #(.W(POS_W), .INIT(SAVED_INIT)) u_nv (
        .clk     (clk),
        .wr_en   (nv_wr),
        .wr_data (pos_o),
        .rd_data (nv_val)
    );

    tapsel_counter #(.W(POS_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load_val (nv_val),
        .up_en    (up_en),
        .dn_en    (dn_en),
        .q        (pos_o)
    );

    tapsel_decode #(.W(POS_W)) u_dec (
        .pos    (pos_o),
        .onehot (tap_o)
    );

endmodule

// File: rtl/tapsel_ctrl_chk.sv
module tapsel_ctrl_chk #(
    parameter int  POS_W = 5,
    localparam int TAPS  = 1 << POS_W
) (
    input logic              clk,
    input logic              rst,
    input logic [TAPS-1:0]   tap_o,
    input logic [POS_W-1:0]  pos_o,
    input logic              busy_o,
    input logic              standby_o
);

    localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};

    assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        ($countones(tap_o) == 1) && tap_o[pos_o]);

    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pos_o == $past(pos_o)) ||
                        (pos_o == $past(pos_o) + 1'b1) ||
                        (pos_o + 1'b1 == $past(pos_o)));

    assert_no_wrap_top_R3: assert property (@(posedge clk) disable iff (rst)
        (pos_o == TOP) |=> (pos_o != '0));

    assert_no_wrap_bot_R3: assert property (@(posedge clk) disable iff (rst)
        (pos_o == '0) |=> (pos_o != TOP));

    assert_frozen_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(pos_o));

    assert_excl_status_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({busy_o, standby_o}));

endmodule

bind tapsel_ctrl tapsel_ctrl_chk #(.POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tap_o     (tap_o),
    .pos_o     (pos_o),
    .busy_o    (busy_o),
    .standby_o (standby_o)
);

// File: tb/tapsel_ctrl_tb.sv
`timescale 1ns/1ps
module tapsel_ctrl_tb;

    localparam int          POS_W     = 5;
    localparam int          TAPS      = 1 << POS_W;
    localparam int          STORE_CYC = 20;
    localparam logic [4:0]  INIT_POS  = 5'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n_i = 1'b1;
    logic step_i = 1'b0;
    logic dir_i = 1'b0;
    logic [TAPS-1:0]  tap_o;
    logic [POS_W-1:0] pos_o;
    logic busy_o, standby_o;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        string      req;
        int         pos;
        logic       busy;
        logic       stby;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    tapsel_ctrl #(
        .POS_W(POS_W), .STORE_CYCLES(STORE_CYC), .SAVED_INIT(INIT_POS)
    ) u_dut (
        .clk(clk), .rst(rst), .sel_n_i(sel_n_i), .step_i(step_i), .dir_i(dir_i),
        .tap_o(tap_o), .pos_o(pos_o), .busy_o(busy_o), .standby_o(standby_o)
    );

    // Monitor: pops expected items and compares against live outputs
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t it;
            logic [TAPS-1:0] exp_tap;
            it = exp_q.pop_front();
            exp_tap = TAPS'(1) << it.pos;
            n_chk++;
            if (pos_o !== POS_W'(it.pos) || tap_o !== exp_tap ||
                busy_o !== it.busy || standby_o !== it.stby) begin
                n_fail++;
                $display("FAIL %s: pos=%0d tap=%h busy=%b stby=%b expected pos=%0d tap=%h busy=%b stby=%b",
                         it.req, pos_o, tap_o, busy_o, standby_o,
                         it.pos, exp_tap, it.busy, it.stby);
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(string req, int pos, logic busy, logic stby);
        exp_t it;
        it.req = req; it.pos = pos; it.busy = busy; it.stby = stby;
        @(posedge clk); #1;
        exp_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic check_val(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(5);
    endtask

    task automatic step(logic up);
        dir_i = up;
        wait_cyc(3);
        step_i = 1'b1;
        wait_cyc(3);
        step_i = 1'b0;
        wait_cyc(4);
    endtask

    task automatic select_ch();
        sel_n_i = 1'b0;
        wait_cyc(5);
    endtask

    task automatic release_plain();
        step_i = 1'b0;
        wait_cyc(3);
        sel_n_i = 1'b1;
        wait_cyc(5);
    endtask

    task automatic release_save();
        int n = 0;
        step_i = 1'b1;
        wait_cyc(3);
        sel_n_i = 1'b1;
        for (int g = 0; g < 200; g++) begin
            @(negedge clk);
            if (busy_o) n++;
            else if (n > 0) break;
        end
        step_i = 1'b0;
        check_val("R7 busy length", n, STORE_CYC);
        wait_cyc(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R6: empty store recalls SAVED_INIT; R1 decode; R10 standby
        do_reset();
        expect_out("R6 initial recall", 3, 1'b0, 1'b1);

        // R11: steps while deselected are ignored
        step(1'b1);
        step(1'b1);
        expect_out("R11 deselected steps", 3, 1'b0, 1'b1);

        select_ch();
        expect_out("R10 selected not standby", 3, 1'b0, 1'b0);

        // R2 up steps, R9 direction change within one selection
        step(1'b1);
        step(1'b1);
        expect_out("R2 up twice", 5, 1'b0, 1'b0);
        step(1'b0);
        expect_out("R9 down after up", 4, 1'b0, 1'b0);

        // R3 bottom saturation
        for (int i = 0; i < 6; i++) step(1'b0);
        expect_out("R3 saturate at 0", 0, 1'b0, 1'b0);

        // R3 top saturation
        for (int i = 0; i < 35; i++) step(1'b1);
        expect_out("R3 saturate at 31", 31, 1'b0, 1'b0);
        step(1'b1);
        expect_out("R3 extra up at 31", 31, 1'b0, 1'b0);

        for (int i = 0; i < 3; i++) step(1'b0);
        expect_out("R2 down to 28", 28, 1'b0, 1'b0);

        // R4/R7 save exit
        release_save();
        expect_out("R7 standby after store", 28, 1'b0, 1'b1);

        // R8: steps and reselect during busy are ignored
        select_ch();
        step(1'b0);
        expect_out("R2 down to 27", 27, 1'b0, 1'b0);
        step_i = 1'b1;
        wait_cyc(3);
        sel_n_i = 1'b1;
        wait_cyc(4);
        sel_n_i = 1'b0;
        step_i = 1'b0;
        wait_cyc(2);
        dir_i = 1'b1;
        step_i = 1'b1;
        wait_cyc(3);
        step_i = 1'b0;
        expect_out("R8 frozen while busy", 27, 1'b1, 1'b0);
        for (int g = 0; g < 100 && busy_o; g++) @(negedge clk);
        wait_cyc(5);
        expect_out("R8 after busy, active, unchanged", 27, 1'b0, 1'b0);

        // R5: plain exit keeps live value, no store
        step(1'b1);
        step(1'b1);
        expect_out("R2 up to 29", 29, 1'b0, 1'b0);
        release_plain();
        expect_out("R5 plain exit", 29, 1'b0, 1'b1);
        expect_out("R10 standby after plain exit", 29, 1'b0, 1'b1);

        // R6/R4: power cycle recalls last stored value (27), not live 29
        do_reset();
        expect_out("R4 R6 recall stored", 27, 1'b0, 1'b1);

        wait_cyc(3);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule